// File: doc/BRIEF.md
# Daisy-Chain Peripheral Frame Engine

This block is the byte-level frame logic of one peripheral in a serial daisy chain of up to 63 devices. It sees each byte after deserialization from the serial input, and it supplies the byte to be serialized onto the serial output in the next byte slot. An active-low chip select brackets each frame. Within a frame the engine sorts the incoming bytes. Bytes that arrive before the first header are status bytes from the devices ahead of it in the chain, and their count gives the engine its own position. The first header carries the chain length n. The second header carries a global fault-clear flag and spare bits. After the headers come the command and data bytes, furthest device first.

Every received byte leaves on the output exactly one byte slot later. This includes pass bytes and the spare bits. There are two exceptions. The first slot of a frame carries the device's own status byte. Slot n+2 carries its report byte, and that slot holds this device's own command byte, which has already been used. Because every device inserts its report at the same slot number and adds one slot of delay, the controller receives all the status bytes, then the two headers, then all the report bytes, furthest device first in each group.

Each upstream device shifts the headers and the command bytes by the same amount. As a result, every device finds its own command at received-byte index n+1 and its own data at index 2n+1, counting from 0 at the first byte of the frame. The engine latches both bytes. It acts on them only when chip select rises, and only if the frame is well formed.

Top module: `chain_frame_engine`

## Requirements
- R1: A byte whose two leading bits are 10 is a header. Before the first header, every other byte (including ones with leading bits 11) counts as a status byte. The device position equals that count plus one.
- R2: The chain length n is taken from bits 5:0 of the first header. The device latches the byte at received index n+1 as its command and the byte at index 2n+1 as its data (indices start at 0 at the first byte of the frame).
- R3: `txByte` equals `statusByte` while chip select is high and during the first byte slot of a frame, before any byte has been received.
- R4: Once byte k has been received, `txByte` carries that byte unchanged, including pass bytes and header spare bits. The only exception is R5.
- R5: Once byte n+1 has been received, and both headers came earlier in the frame, `txByte` carries `reportByte`.
- R6: In the cycle after chip select is sampled high following a good frame, `cmdValid` pulses for exactly one cycle, and `cmdOut` and `dataOut` hold the latched command and data.
- R7: If the received byte count differs from 2n+2, `frameErr` pulses at the chip-select rise and `cmdValid` stays low.
- R8: `frameErr` also pulses, with no `cmdValid`, in any of these cases: no header was received, n is 0, n exceeds MAX_DEVICES, the second header's leading bits are not 10, or the position exceeds n.
- R9: `clrFault` pulses at the chip-select rise when the second header has leading bits 10 and bit 5 set. This happens even if the frame is rejected.
- R10: If the byte in the device's own command slot or data slot has leading bits 11, the engine neither applies the command nor flags an error.
- R11: A chip-select rise restarts counting and header detection. Bytes that arrive while chip select is high are ignored. A frame that contains no bytes produces no pulse.
- R12: A chain of 63 devices is handled: position 63 with n = 63 and a 128-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select, synchronous |
| rxValid | input | 1 | One received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| statusByte | input | 8 | This device's status byte |
| reportByte | input | 8 | This device's report byte |
| txByte | output | 8 | Byte to be shifted out in the current slot |
| cmdValid | output | 1 | One-cycle pulse: apply the command |
| cmdOut | output | 8 | Command byte applied |
| dataOut | output | 8 | Data byte applied |
| frameErr | output | 1 | One-cycle pulse: frame rejected |
| clrFault | output | 1 | One-cycle pulse: chain-wide fault clear |

## Verification
The hardest case to reach is a device deep in a long chain, because it needs a frame of the exact length built around a long run of status bytes. The bench creates it directly: it prepends 62 status bytes to a 63-device frame, so that the command and data indices reach 64 and 127. The report insertion and the pass-byte case in the device's own slot also need the headers to land at particular offsets. The bench therefore builds every frame from the position it wants to test, and works out the expected output slot by slot from the byte list.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int BYTE_W = 8;
  localparam int NFIELD_W = 6;
  localparam logic [1:0] KIND_HDR  = 2'b10;
  localparam logic [1:0] KIND_PASS = 2'b11;
  localparam int CLR_BIT = 5;

  typedef enum logic [1:0] {HS_NONE, HS_ONE, HS_BOTH} hdrStateT;

  typedef struct packed {
    logic fwdLoad;   // a byte was taken this cycle
    logic frameIdle; // chip select high
    logic capHdr2;   // second header byte present
    logic capCmd;    // own command byte present
    logic capData;   // own data byte present
    logic repSet;    // next output slot carries the report
    logic commit;    // frame good, apply
    logic reject;    // frame bad
    logic endFrame;  // chip select rising
  } strobeT;
endpackage

// File: rtl/cfe_ctrl.sv
module cfe_ctrl
  import cfe_pkg::*;
#(
  parameter int MAX_DEVICES = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output strobeT            strb
);
  localparam int CNT_W = $clog2(2 * MAX_DEVICES + 3) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [NFIELD_W-1:0] POS_MAX = '1;
  localparam logic [NFIELD_W-1:0] DEV_LIM = NFIELD_W'(MAX_DEVICES);

  logic csPrevQ;
  logic [CNT_W-1:0] byteCnt;
  logic [NFIELD_W-1:0] statCnt;
  logic [NFIELD_W-1:0] nQ;
  hdrStateT hdrSt;
  logic hdrErrQ;
  logic ownPassQ;

  logic take, isHdr, isPass, csRise, hitCmd, hitData, frameGood;
  logic [CNT_W-1:0] idxCmd, idxData, lenWant;

  always_comb begin
    isHdr   = rxByte[7:6] == KIND_HDR;
    isPass  = rxByte[7:6] == KIND_PASS;
    take    = rxValid && !csN;
    csRise  = csN && !csPrevQ;
    idxCmd  = CNT_W'(nQ) + CNT_W'(1);
    idxData = CNT_W'(nQ) + CNT_W'(nQ) + CNT_W'(1);
    lenWant = idxData + CNT_W'(1);
    hitCmd  = take && hdrSt == HS_BOTH && byteCnt == idxCmd;
    hitData = take && hdrSt == HS_BOTH && byteCnt == idxData;
    frameGood = hdrSt == HS_BOTH && !hdrErrQ && nQ != '0 && nQ <= DEV_LIM
                && statCnt < nQ && byteCnt == lenWant;
    strb.fwdLoad   = take;
    strb.frameIdle = csN;
    strb.capHdr2   = take && hdrSt == HS_ONE;
    strb.capCmd    = hitCmd && !isPass;
    strb.capData   = hitData && !isPass;
    strb.repSet    = hitCmd;
    strb.commit    = csRise && byteCnt != '0 && frameGood && !ownPassQ;
    strb.reject    = csRise && byteCnt != '0 && !frameGood;
    strb.endFrame  = csRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) csPrevQ <= 1'b1;
    else       csPrevQ <= csN;
  end

  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      byteCnt  <= '0;
      statCnt  <= '0;
      nQ       <= '0;
      hdrSt    <= HS_NONE;
      hdrErrQ  <= 1'b0;
      ownPassQ <= 1'b0;
    end else if (take) begin
      if (byteCnt != CNT_MAX) byteCnt <= byteCnt + CNT_W'(1);
      case (hdrSt)
        HS_NONE: begin
          if (isHdr) begin
            hdrSt <= HS_ONE;
            nQ    <= rxByte[NFIELD_W-1:0];
          end else if (statCnt != POS_MAX) begin
            statCnt <= statCnt + NFIELD_W'(1);
          end
        end
        HS_ONE: begin
          hdrSt <= HS_BOTH;
          if (!isHdr) hdrErrQ <= 1'b1;
        end
        default: ;
      endcase
      if ((hitCmd || hitData) && isPass) ownPassQ <= 1'b1;
    end
  end

  // R11
  cnt_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (byteCnt == '0 && hdrSt == HS_NONE));

  // R1
  pos_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && hdrSt != HS_NONE) |=> (csN || $stable(statCnt)));
endmodule

// File: rtl/cfe_dpath.sv
module cfe_dpath
  import cfe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  strobeT            strb,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [BYTE_W-1:0] statusByte,
  input  logic [BYTE_W-1:0] reportByte,
  output logic [BYTE_W-1:0] txByte,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdOut,
  output logic [BYTE_W-1:0] dataOut,
  output logic              frameErr,
  output logic              clrFault
);
  logic [BYTE_W-1:0] fwdQ, cmdLatQ, dataLatQ;
  logic sentAnyQ, repSlotQ, clrBitQ;

  always_comb begin
    if (csN || !sentAnyQ) txByte = statusByte;
    else if (repSlotQ)    txByte = reportByte;
    else                  txByte = fwdQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.frameIdle) begin
      sentAnyQ <= 1'b0;
      repSlotQ <= 1'b0;
      fwdQ     <= '0;
    end else if (strb.fwdLoad) begin
      sentAnyQ <= 1'b1;
      repSlotQ <= strb.repSet;
      fwdQ     <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLatQ  <= '0;
      dataLatQ <= '0;
      clrBitQ  <= 1'b0;
    end else begin
      if (strb.capCmd)  cmdLatQ  <= rxByte;
      if (strb.capData) dataLatQ <= rxByte;
      if (strb.frameIdle)    clrBitQ <= 1'b0;
      else if (strb.capHdr2) clrBitQ <= rxByte[7:6] == KIND_HDR && rxByte[CLR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      frameErr <= 1'b0;
      clrFault <= 1'b0;
      cmdOut   <= '0;
      dataOut  <= '0;
    end else begin
      cmdValid <= strb.commit;
      frameErr <= strb.reject;
      clrFault <= strb.endFrame && clrBitQ;
      if (strb.commit) begin
        cmdOut  <= cmdLatQ;
        dataOut <= dataLatQ;
      end
    end
  end

  // R3
  tx_idle_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> txByte == statusByte);

  // R6
  cmd_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($past(csN) && !$past(csN, 2)));

  // R6
  cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R7
  cmd_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && frameErr));

  // R9
  clr_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrFault |-> ($past(csN) && !$past(csN, 2)));
endmodule

// File: rtl/chain_frame_engine.sv
module chain_frame_engine
  import cfe_pkg::*;
#(
  parameter int MAX_DEVICES = 63
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic [7:0] statusByte,
  input  logic [7:0] reportByte,
  output logic [7:0] txByte,
  output logic       cmdValid,
  output logic [7:0] cmdOut,
  output logic [7:0] dataOut,
  output logic       frameErr,
  output logic       clrFault
);
  strobeT strb;

  cfe_ctrl #(.MAX_DEVICES(MAX_DEVICES)) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .strb(strb)
  );

  cfe_dpath i_dpath (
    .clk(clk), .rstN(rstN), .csN(csN), .strb(strb), .rxByte(rxByte),
    .statusByte(statusByte), .reportByte(reportByte), .txByte(txByte),
    .cmdValid(cmdValid), .cmdOut(cmdOut), .dataOut(dataOut),
    .frameErr(frameErr), .clrFault(clrFault)
  );
endmodule

// File: tb/test_chain_frame_engine.sv
module test_chain_frame_engine;
  localparam int CLK_PERIOD = 10;
  localparam int K_TX = 0, K_CV = 1, K_FE = 2, K_CF = 3, K_CO = 4, K_DO = 5;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, rxValid = 1'b0;
  logic [7:0] rxByte = '0, statusByte = 8'hE5, reportByte = 8'h5A;
  logic [7:0] txByte, cmdOut, dataOut;
  logic cmdValid, frameErr, clrFault;

  chain_frame_engine i_chain_frame_engine (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .statusByte(statusByte), .reportByte(reportByte), .txByte(txByte),
    .cmdValid(cmdValid), .cmdOut(cmdOut), .dataOut(dataOut),
    .frameErr(frameErr), .clrFault(clrFault)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int    due;
    int    kind;
    int    exp;
    string req;
  } itemT;

  itemT sbq[$];
  logic [7:0] fr[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic pushExp(int due, int kind, int exp, string req);
    itemT it;
    it.due = due; it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: pops due items and compares them with the ports
  always @(negedge clk) begin
    itemT it;
    int act;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      it = sbq.pop_front();
      case (it.kind)
        K_TX:    act = int'(txByte);
        K_CV:    act = int'(cmdValid);
        K_FE:    act = int'(frameErr);
        K_CF:    act = int'(clrFault);
        K_CO:    act = int'(cmdOut);
        default: act = int'(dataOut);
      endcase
      check(it.req, act, it.exp);
    end
  end

  // driver: sends the frame in fr and pushes the expected results
  task automatic runFrame(int gap, string req);
    int len, h, n, repSlot;
    bit good, ownPass, commit, err, clr;
    len = fr.size();
    h = -1;
    for (int i = 0; i < len; i++)
      if (h < 0 && fr[i][7:6] == 2'b10) h = i;
    n = (h >= 0) ? int'(fr[h][5:0]) : 0;
    repSlot = (h >= 0 && h + 1 < n + 1) ? n + 2 : -1;
    good = h >= 0 && h + 1 < len && fr[h+1][7:6] == 2'b10 && n != 0 && n <= 63
           && h < n && len == 2 * n + 2;
    ownPass = good && (fr[n+1][7:6] == 2'b11 || fr[2*n+1][7:6] == 2'b11);
    commit = len > 0 && good && !ownPass;
    err = len > 0 && !good;
    clr = h >= 0 && h + 1 < len && fr[h+1][7:6] == 2'b10 && fr[h+1][5];

    @(negedge clk); #1;
    csN = 1'b0;
    pushExp(cyc + 1, K_TX, int'(statusByte), "R3 first slot");
    for (int i = 0; i < len; i++) begin
      int ex;
      @(negedge clk); #1;
      rxValid = 1'b1;
      rxByte = fr[i];
      ex = (i + 1 == repSlot) ? int'(reportByte) : int'(fr[i]);
      pushExp(cyc + 1, K_TX, ex, (i + 1 == repSlot) ? "R5 report slot" : "R4 forward");
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); #1;
        rxValid = 1'b0;
        pushExp(cyc + 1, K_TX, ex, "R4 held across gap");
      end
    end
    @(negedge clk); #1;
    rxValid = 1'b0;
    csN = 1'b1;
    pushExp(cyc + 1, K_CV, int'(commit), {req, " cmdValid"});
    pushExp(cyc + 1, K_FE, int'(err), {req, " frameErr"});
    pushExp(cyc + 1, K_CF, int'(clr), {req, " R9 clrFault"});
    pushExp(cyc + 1, K_TX, int'(statusByte), "R3 idle status");
    if (commit) begin
      pushExp(cyc + 1, K_CO, int'(fr[n+1]), {req, " R2 cmdOut"});
      pushExp(cyc + 1, K_DO, int'(fr[2*n+1]), {req, " R2 dataOut"});
    end
    pushExp(cyc + 2, K_CV, 0, "R6 single pulse");
    pushExp(cyc + 2, K_FE, 0, "R7 single pulse");
    repeat (3) @(negedge clk);
    fr.delete();
  endtask

  task automatic addStd(int n, int pos, logic [7:0] h2);
    for (int i = 0; i < pos - 1; i++) fr.push_back(8'hC0 | 8'(i & 6'h3F));
    fr.push_back(8'h80 | 8'(n));
    fr.push_back(h2);
  endtask

  task automatic addBody(int count, logic [7:0] base);
    for (int i = 0; i < count; i++) fr.push_back(base + 8'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    pushExp(cyc + 1, K_TX, int'(statusByte), "R3 reset");
    pushExp(cyc + 1, K_CV, 0, "R6 reset");
    pushExp(cyc + 1, K_FE, 0, "R7 reset");
    pushExp(cyc + 1, K_CF, 0, "R9 reset");
    repeat (2) @(negedge clk);

    // R2 position 1 of 3, spare bits forwarded
    addStd(3, 1, 8'h95); addBody(6, 8'h11);
    runFrame(0, "R2 pos1");

    // R1 position 2 of 3, status byte with leading 11
    statusByte = 8'hC3; reportByte = 8'h3C;
    addStd(3, 2, 8'h8A); addBody(5, 8'h21);
    runFrame(0, "R1 pos2");

    // R9 position 3 of 3 with fault clear, gapped bytes
    addStd(3, 3, 8'hA0); addBody(4, 8'h31);
    runFrame(2, "R9 pos3");

    // R8 count of zero
    addStd(0, 1, 8'hA0);
    runFrame(0, "R8 zero count");

    // R7 one byte short
    addStd(2, 1, 8'h80); addBody(3, 8'h05);
    runFrame(0, "R7 short");

    // R7 one byte long, clear still applied
    addStd(2, 1, 8'hA3); addBody(5, 8'h05);
    runFrame(0, "R7 long");

    // R10 pass byte in own command slot
    addStd(2, 1, 8'h80); fr.push_back(8'h01); fr.push_back(8'hF7);
    fr.push_back(8'h02); fr.push_back(8'h03);
    runFrame(0, "R10 pass cmd");

    // R10 pass byte in own data slot
    addStd(2, 2, 8'h80); fr.push_back(8'h01); fr.push_back(8'h02);
    fr.push_back(8'hEE);
    runFrame(0, "R10 pass data");

    // R8 position beyond chain length
    addStd(2, 4, 8'h80); fr.push_back(8'h07);
    runFrame(0, "R8 pos beyond n");

    // R8 second header of wrong kind, no clear
    addStd(2, 1, 8'h20); addBody(4, 8'h09);
    runFrame(0, "R8 bad hdr2");

    // R8 no header at all
    addBody(4, 8'h01);
    runFrame(0, "R8 no header");

    // R11 empty frame
    runFrame(0, "R11 empty");

    // R11 bytes while chip select high are ignored
    @(negedge clk); #1;
    rxValid = 1'b1; rxByte = 8'h83;
    pushExp(cyc + 1, K_TX, int'(statusByte), "R11 ignored tx");
    @(negedge clk); #1;
    rxByte = 8'hC1;
    pushExp(cyc + 1, K_CV, 0, "R11 ignored no cmd");
    pushExp(cyc + 1, K_FE, 0, "R11 ignored no err");
    @(negedge clk); #1;
    rxValid = 1'b0;
    addStd(1, 1, 8'h80); addBody(2, 8'h41);
    runFrame(0, "R11 after ignored");

    // R12 deepest device in a 63-device chain
    statusByte = 8'h99; reportByte = 8'h66;
    addStd(63, 63, 8'hBF); addBody(64, 8'h00);
    runFrame(0, "R12 pos63");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule